// File: doc/BRIEF.md
# Machine Cycle Sequencer

This block paces a small 8-bit processor through the machine cycles and clock states of each instruction. It does not decode opcodes. A decoder outside the block supplies, for the instruction now held, a handful of active-low timing flags: one that drops both read cycles, one that drops only the first read cycle, one that stretches the opcode fetch, and a three-bit code that names the final cycle. Two further inputs describe a conditional instruction whose condition has failed, so that it can stop early.

The cycles always run in one fixed order: opcode fetch (M1), first read (R1), second read (R2), first write (W1), second write (W2). Any of these cycles may be missing. The block reports the current cycle type and the clock state inside that cycle. In the final state of the final cycle it raises a one-cycle end strobe. The next opcode fetch follows on the very next clock. A restart input drops any cycle in progress and returns the sequencer to the start of a fetch.

Top module: `mcyc_sequencer`

## Requirements
- R1: The `cycle` output takes the codes M1=0, R1=1, R2=2, W1=3 and W2=4. Within one instruction, successive cycles only move forward in the order M1, R1, R2, W1, W2, and every instruction starts with M1.
- R2: M1 lasts 4 clock states when `long_fetch_n` is high and 6 clock states when it is low.
- R3: Every cycle other than M1 lasts exactly 3 clock states.
- R4: After M1 the next cycle is W1 when `skip_both_n` is low, R2 when only `skip_first_n` is low, and R1 otherwise. R1 is always followed by R2, R2 by W1, and W1 by W2.
- R5: `end_code_n` names the final cycle: 3'b111 means M1, 3'b100 means R1, 3'b101 means R2, 3'b110 means W1, 3'b011 means W2, and any other value means M1. A cycle is the final one when the cycle that would follow it lies later in the order than the named cycle. W2 is always final.
- R6: `end_strobe` is high only during the last clock state of the final cycle. The clock after it shows cycle M1 in state 1.
- R7: While `cond_fail` is high, the instruction ends after M1 if `cond_ret` is high, and ends no later than R2 if `cond_ret` is low. If the end code names an earlier cycle, that earlier end still applies.
- R8: A synchronous high `rst` puts the sequencer in M1 state 1. With `long_fetch_n` high, `end_strobe` is then low.
- R9: A high `restart` sampled at a clock edge puts the sequencer in M1 state 1 on that edge, whatever cycle was running.
- R10: With `T_ONEHOT`=1, `t_state` is one-hot, with bit k high in state k+1. With `T_ONEHOT`=0, it holds the state number in binary, starting at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| restart | input | 1 | Abandon the current instruction and fetch again |
| skip_both_n | input | 1 | Active low: drop R1 and R2 |
| skip_first_n | input | 1 | Active low: drop R1 only |
| long_fetch_n | input | 1 | Active low: M1 takes 6 states |
| end_code_n | input | 3 | Active-low code naming the final cycle |
| cond_fail | input | 1 | Condition of a conditional instruction not met |
| cond_ret | input | 1 | Failed conditional is a return (end after M1) |
| cycle | output | 3 | Current machine cycle code |
| t_state | output | LONG_FETCH or clog2(LONG_FETCH+1) | Current clock state, one-hot or binary |
| end_strobe | output | 1 | Last state of the instruction |

## Verification
A wrong cycle register shows at once on `cycle`, and it changes the total state count the bench measures for that instruction. A wrong state counter makes a cycle too short or too long. That shows on `t_state` within the first cycle, and it moves `end_strobe` by at least one clock. A bad route or end decision shows at the first T1 of the wrong cycle, or as an end strobe that comes early or never comes. The sweep covers every end code, skip setting, fetch length and failed-condition kind, so each such fault is caught within the instruction it affects.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
   typedef enum logic [2:0] {
      CYC_M1 = 3'd0,
      CYC_R1 = 3'd1,
      CYC_R2 = 3'd2,
      CYC_W1 = 3'd3,
      CYC_W2 = 3'd4
   } cyc_e;
endpackage

// File: rtl/mseq_route.sv
module mseq_route
   import mseq_pkg::*;
(
   input  cyc_e       cur,
   input  logic       skip_both_n,
   input  logic       skip_first_n,
   input  logic [2:0] end_code_n,
   input  logic       cond_fail,
   input  logic       cond_ret,
   output cyc_e       nxt,
   output logic       is_last
);
   cyc_e nat_end;
   cyc_e forced_end;
   cyc_e eff_end;

   always_comb begin
      unique case (end_code_n)
         3'b111:  nat_end = CYC_M1;
         3'b100:  nat_end = CYC_R1;
         3'b101:  nat_end = CYC_R2;
         3'b110:  nat_end = CYC_W1;
         3'b011:  nat_end = CYC_W2;
         default: nat_end = CYC_M1;
      endcase
   end

   always_comb begin
      if (!cond_fail)    forced_end = CYC_W2;
      else if (cond_ret) forced_end = CYC_M1;
      else               forced_end = CYC_R2;
      eff_end = (forced_end < nat_end) ? forced_end : nat_end;
   end

   always_comb begin
      unique case (cur)
         CYC_M1:  nxt = !skip_both_n ? CYC_W1 : (!skip_first_n ? CYC_R2 : CYC_R1);
         CYC_R1:  nxt = CYC_R2;
         CYC_R2:  nxt = CYC_W1;
         CYC_W1:  nxt = CYC_W2;
         default: nxt = CYC_M1;
      endcase
      is_last = (cur == CYC_W2) || (nxt > eff_end);
   end
endmodule

// File: rtl/mseq_len.sv
module mseq_len
   import mseq_pkg::*;
#(
   parameter int SHORT_FETCH = 4,
   parameter int LONG_FETCH  = 6,
   parameter int MEM_STATES  = 3,
   parameter int TW          = 3
) (
   input  cyc_e          cur,
   input  logic          long_fetch_n,
   output logic [TW-1:0] len
);
   localparam logic [TW-1:0] L_SHORT = TW'(SHORT_FETCH);
   localparam logic [TW-1:0] L_LONG  = TW'(LONG_FETCH);
   localparam logic [TW-1:0] L_MEM   = TW'(MEM_STATES);

   always_comb begin
      if (cur == CYC_M1) len = long_fetch_n ? L_SHORT : L_LONG;
      else               len = L_MEM;
   end
endmodule

// File: rtl/mseq_tcode.sv
module mseq_tcode #(
   parameter int TW      = 3,
   parameter int NSTATE  = 6,
   parameter bit ONEHOT  = 1'b1,
   parameter int OW      = 6
) (
   input  logic [TW-1:0] tcnt,
   output logic [OW-1:0] code
);
   if (ONEHOT) begin : g_onehot
      for (genvar k = 0; k < NSTATE; k++) begin : g_bit
         assign code[k] = (tcnt == TW'(k + 1));
      end
   end else begin : g_binary
      assign code = OW'(tcnt);
   end
endmodule

// File: rtl/mcyc_sequencer.sv
module mcyc_sequencer
   import mseq_pkg::*;
#(
   parameter int SHORT_FETCH = 4,
   parameter int LONG_FETCH  = 6,
   parameter int MEM_STATES  = 3,
   parameter bit T_ONEHOT    = 1'b1,
   localparam int TW  = $clog2(LONG_FETCH + 1),
   localparam int TSW = T_ONEHOT ? LONG_FETCH : TW
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           restart,
   input  logic           skip_both_n,
   input  logic           skip_first_n,
   input  logic           long_fetch_n,
   input  logic [2:0]     end_code_n,
   input  logic           cond_fail,
   input  logic           cond_ret,
   output logic [2:0]     cycle,
   output logic [TSW-1:0] t_state,
   output logic           end_strobe
);
   if (SHORT_FETCH < 1 || LONG_FETCH < SHORT_FETCH) begin : g_bad_fetch
      $error("fetch lengths must satisfy 1 <= SHORT_FETCH <= LONG_FETCH");
   end
   if (MEM_STATES < 1 || MEM_STATES > LONG_FETCH) begin : g_bad_mem
      $error("MEM_STATES must lie between 1 and LONG_FETCH");
   end

   localparam logic [TW-1:0] T_FIRST = TW'(1);

   cyc_e          cyc_q;
   logic [TW-1:0] tcnt;
   cyc_e          nxt;
   logic          is_last;
   logic [TW-1:0] len;
   logic          at_end;

   mseq_route u_route (
      .cur          (cyc_q),
      .skip_both_n  (skip_both_n),
      .skip_first_n (skip_first_n),
      .end_code_n   (end_code_n),
      .cond_fail    (cond_fail),
      .cond_ret     (cond_ret),
      .nxt          (nxt),
      .is_last      (is_last)
   );

   mseq_len #(
      .SHORT_FETCH (SHORT_FETCH),
      .LONG_FETCH  (LONG_FETCH),
      .MEM_STATES  (MEM_STATES),
      .TW          (TW)
   ) u_len (
      .cur          (cyc_q),
      .long_fetch_n (long_fetch_n),
      .len          (len)
   );

   mseq_tcode #(
      .TW     (TW),
      .NSTATE (LONG_FETCH),
      .ONEHOT (T_ONEHOT),
      .OW     (TSW)
   ) u_tcode (
      .tcnt (tcnt),
      .code (t_state)
   );

   assign at_end     = (tcnt == len);
   assign end_strobe = at_end && is_last;
   assign cycle      = cyc_q;

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         cyc_q <= CYC_M1;
         tcnt  <= T_FIRST;
      end else if (at_end) begin
         cyc_q <= is_last ? CYC_M1 : nxt;
         tcnt  <= T_FIRST;
      end else begin
         tcnt  <= tcnt + T_FIRST;
      end
   end
endmodule

// File: rtl/mseq_checker.sv
module mseq_checker #(
   parameter int SHORT_FETCH = 4,
   parameter int LONG_FETCH  = 6,
   parameter int MEM_STATES  = 3,
   parameter int TW          = 3
) (
   input logic          clk,
   input logic          rst,
   input logic          restart,
   input logic          long_fetch_n,
   input logic [2:0]    cycle,
   input logic [TW-1:0] tcnt,
   input logic          end_strobe
);
   localparam logic [2:0] C_M1 = 3'd0;
   localparam logic [2:0] C_W2 = 3'd4;

   p_order_r1: assert property (@(posedge clk) disable iff (rst)
      (cycle != $past(cycle)) |-> (cycle == C_M1 || cycle > $past(cycle)));

   p_short_fetch_r2: assert property (@(posedge clk) disable iff (rst)
      (cycle == C_M1 && tcnt == TW'(SHORT_FETCH) && long_fetch_n && !restart)
      |=> (tcnt == TW'(1)));

   p_mem_len_r3: assert property (@(posedge clk) disable iff (rst)
      (cycle != C_M1) |-> (tcnt >= TW'(1) && tcnt <= TW'(MEM_STATES)));

   p_w2_final_r5: assert property (@(posedge clk) disable iff (rst)
      (cycle == C_W2 && tcnt == TW'(MEM_STATES)) |-> end_strobe);

   p_strobe_refetch_r6: assert property (@(posedge clk) disable iff (rst)
      (end_strobe && !restart) |=> (cycle == C_M1 && tcnt == TW'(1)));

   p_reset_state_r8: assert property (@(posedge clk)
      rst |=> (cycle == C_M1 && tcnt == TW'(1)));

   p_restart_r9: assert property (@(posedge clk) disable iff (rst)
      restart |=> (cycle == C_M1 && tcnt == TW'(1)));
endmodule

bind mcyc_sequencer mseq_checker #(
   .SHORT_FETCH (SHORT_FETCH),
   .LONG_FETCH  (LONG_FETCH),
   .MEM_STATES  (MEM_STATES),
   .TW          (TW)
) u_mseq_checker (
   .clk          (clk),
   .rst          (rst),
   .restart      (restart),
   .long_fetch_n (long_fetch_n),
   .cycle        (cycle),
   .tcnt         (tcnt),
   .end_strobe   (end_strobe)
);

// File: tb/mcyc_sequencer_bench.sv
`timescale 1ns/1ps
module mcyc_sequencer_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       restart = 1'b0;
   logic       skip_both_n = 1'b1;
   logic       skip_first_n = 1'b1;
   logic       long_fetch_n = 1'b1;
   logic [2:0] end_code_n = 3'b111;
   logic       cond_fail = 1'b0;
   logic       cond_ret = 1'b0;
   logic [2:0] cycle, cycle_b;
   logic [5:0] t_state;
   logic [2:0] t_state_b;
   logic       end_strobe, end_strobe_b;

   int checks = 0;
   int failures = 0;
   int clk_count = 0;

   always #5 clk = ~clk;

   mcyc_sequencer u_mcyc_sequencer (
      .clk(clk), .rst(rst), .restart(restart),
      .skip_both_n(skip_both_n), .skip_first_n(skip_first_n),
      .long_fetch_n(long_fetch_n), .end_code_n(end_code_n),
      .cond_fail(cond_fail), .cond_ret(cond_ret),
      .cycle(cycle), .t_state(t_state), .end_strobe(end_strobe)
   );

   mcyc_sequencer #(.T_ONEHOT(1'b0)) u_mcyc_sequencer_bin (
      .clk(clk), .rst(rst), .restart(restart),
      .skip_both_n(skip_both_n), .skip_first_n(skip_first_n),
      .long_fetch_n(long_fetch_n), .end_code_n(end_code_n),
      .cond_fail(cond_fail), .cond_ret(cond_ret),
      .cycle(cycle_b), .t_state(t_state_b), .end_strobe(end_strobe_b)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      clk_count++;
      if (clk_count > 150000) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", clk_count, 150000);
         finish_run();
      end
   end

   function automatic int end_rank(input logic [2:0] code);
      case (code)
         3'b111:  return 0;
         3'b100:  return 1;
         3'b101:  return 2;
         3'b110:  return 3;
         3'b011:  return 4;
         default: return 0;
      endcase
   endfunction

   // Runs one instruction starting at M1 T1; returns at the first M1 T1 after it.
   task automatic run_instr(input bit sb, input bit sf, input bit lg,
                            input logic [2:0] code, input bit cf, input bit cr);
      int eff, n, total, k, tk, seq_idx, guard;
      int exp_seq[5];
      bit seq_ok, t_ok, b_ok;
      skip_both_n  = ~sb;
      skip_first_n = ~sf;
      long_fetch_n = ~lg;
      end_code_n   = code;
      cond_fail    = cf;
      cond_ret     = cr;
      #1;
      eff = end_rank(code);
      if (cf) eff = cr ? 0 : ((eff < 2) ? eff : 2);
      n = 1;
      exp_seq[0] = 0;
      for (int r = 1; r <= 4; r++) begin
         bit dropped;
         dropped = (r == 1 && (sb || sf)) || (r == 2 && sb);
         if (r <= eff && !dropped) begin
            exp_seq[n] = r;
            n++;
         end
      end
      total = (lg ? 6 : 4) + 3 * (n - 1);
      k = 0; tk = 0; seq_idx = 0; guard = 0;
      seq_ok = 1'b1; t_ok = 1'b1; b_ok = 1'b1;
      forever begin
         int prev;
         prev = (k == 0) ? -1 : 0;
         k++;
         tk++;
         if (k > 1 && t_state == 6'b000001) tk = 1;
         if (tk == 1) begin
            if (seq_idx >= n || int'(cycle) != exp_seq[seq_idx]) seq_ok = 1'b0;
            seq_idx++;
         end
         if (t_state != 6'(1 << (tk - 1))) t_ok = 1'b0;
         if (int'(t_state_b) != tk || cycle_b != cycle || end_strobe_b != end_strobe) b_ok = 1'b0;
         if (end_strobe) break;
         guard++;
         if (guard > 40) break;
         @(negedge clk);
      end
      // R2 R3 R5 R7: total length of the instruction in clock states
      check(k == total, "R2/R3/R5/R7 state count", k, total);
      // R1 R4 R5 R7: cycle order, skips and final cycle
      check(seq_ok && seq_idx == n, "R1/R4/R5/R7 cycle sequence", seq_idx, n);
      // R10: one-hot state coding and binary variant agree
      check(t_ok && b_ok, "R10 state coding", int'(t_ok) + 2 * int'(b_ok), 3);
      @(negedge clk);
      // R6: after the strobe a fresh M1 T1
      check(cycle == 3'd0 && t_state == 6'b000001, "R6 refetch", int'(cycle), 0);
   endtask

   initial begin
      logic [2:0] codes[8];
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      // R8: reset state
      check(cycle == 3'd0 && t_state == 6'b000001 && !end_strobe,
            "R8 reset state", int'(t_state), 1);

      // Named examples: register move, long fetch only, M1 R2 W1, full call
      run_instr(0, 0, 0, 3'b111, 0, 0);
      run_instr(0, 0, 1, 3'b111, 0, 0);
      run_instr(0, 1, 0, 3'b110, 0, 0);
      run_instr(0, 0, 1, 3'b011, 0, 0);

      for (int c = 0; c < 8; c++) begin
         for (int s = 0; s < 3; s++) begin
            for (int lg = 0; lg < 2; lg++) begin
               for (int cf = 0; cf < 2; cf++) begin
                  for (int cr = 0; cr < 2; cr++) begin
                     run_instr(s == 1, s == 2, lg[0], 3'(c), cf[0], cr[0]);
                  end
               end
            end
         end
      end

      // R9: restart in the middle of a full five-cycle instruction
      skip_both_n = 1'b1; skip_first_n = 1'b1; long_fetch_n = 1'b0;
      end_code_n = 3'b011; cond_fail = 1'b0; cond_ret = 1'b0;
      repeat (9) @(negedge clk);
      check(cycle != 3'd0, "R9 precondition mid instruction", int'(cycle), 1);
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      #1;
      check(cycle == 3'd0 && t_state == 6'b000001, "R9 restart to fetch",
            int'(cycle), 0);
      run_instr(1, 0, 0, 3'b011, 0, 0);

      finish_run();
   end
endmodule